// File: doc/BRIEF.md
# Sixteen-Bit External Bus Cycle Sequencer

This block turns single requests from a processor core into external bus cycles on a 16-bit data bus. A request carries a byte address, a direction, a memory/IO select, a data/control select, a byte-or-word size, a refresh flag, a flag that says whether ready is produced inside the chip, and the write data. The sequencer accepts one request while idle. It then drives an address strobe for one T1 state and stays in T2 until the cycle ends. A cycle ends when external ready is sampled active, or at once when the request carries the internal-ready flag.

The address, the active-low byte enables and the cycle-definition outputs are loaded when T1 begins. They hold until the next T1. If a device reports an 8-bit width in the last T2 of a word access, the sequencer runs a second cycle for the upper byte and then merges the two halves. A sticky local-access output tracks whether the most recent cycle to reach T2 had internal ready.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `bus_ads_n`=1, `bus_bhe_n`=1, `bus_ble_n`=1, `bus_refresh`=0, `bus_doe`=0, `bus_local_n`=1 and `done`=0.
- R2: `bus_ads_n` is low for exactly one clock (T1), in the cycle after a request is accepted and in the cycle after the first half of a split word ends. It is high in every T2 and idle clock.
- R3: Byte enables are driven from T1 and are active low. A word (`req_word`=1) gives `bus_bhe_n`=0 and `bus_ble_n`=0, with address bit 0 forced to 0. A byte at an even address gives `bus_bhe_n`=1 and `bus_ble_n`=0. A byte at an odd address gives `bus_bhe_n`=0 and `bus_ble_n`=1. A refresh gives `bus_bhe_n`=1, `bus_ble_n`=1 and `bus_refresh`=1.
- R4: In T2, while `bus_ready_n`=1 and the cycle has no internal ready, T2 repeats. Address and byte enables stay unchanged and `done` stays 0.
- R5: In the T2 where the cycle ends, `bus_din` is captured. In the next clock `done` is high for one clock and `rd_data` holds the captured word.
- R6: For a write, `bus_doe`=1 and `bus_dout`=`req_wdata` from T1 to the end of the cycle. `bus_doe` returns to 0 in the following idle state.
- R7: A request with `req_local`=1 ends its first T2 whatever the value of `bus_ready_n`.
- R8: `bus_local_n` goes low in the first T2 of a cycle with internal ready. It stays low through idle states and further such cycles. It goes high again in the first T2 of a cycle without internal ready.
- R9: When `bus_size8_n`=0 in the ending T2 of a word access, one more T1/T2 cycle follows. In that cycle address bit 0 is 1, `bus_bhe_n`=1, `bus_ble_n`=0, and the upper write byte is on `bus_dout[7:0]`. The single `done` returns `rd_data` = {second `bus_din[7:0]`, first `bus_din[7:0]`}.
- R10: `bus_size8_n` has no effect on byte accesses, on refresh cycles, in the second half of a split, or in a T2 that does not end the cycle.
- R11: A refresh cycle never drives data (`bus_doe`=0) and ends on ready like any other cycle.
- R12: `req_ready` is 1 only while idle. A request presented in the clock where `done` is high is accepted, and its T1 follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_addr | input | AW | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = IO |
| req_dc | input | 1 | 1 = data, 0 = control |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_refresh | input | 1 | Refresh cycle |
| req_local | input | 1 | Ready produced internally for this cycle |
| req_wdata | input | DW | Lane-aligned write data |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DW | Captured read data |
| bus_ads_n | output | 1 | Address strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_bhe_n | output | 1 | Upper byte enable, active low |
| bus_ble_n | output | 1 | Lower byte enable, active low |
| bus_wr | output | 1 | Cycle is a write |
| bus_mem | output | 1 | Cycle is a memory access |
| bus_dc | output | 1 | Cycle is a data access |
| bus_refresh | output | 1 | Cycle is a refresh |
| bus_dout | output | DW | Write data |
| bus_doe | output | 1 | Write data driven |
| bus_din | input | DW | Read data |
| bus_ready_n | input | 1 | External ready, active low |
| bus_size8_n | input | 1 | Addressed device is 8 bits wide, active low |
| bus_local_n | output | 1 | Local access flag, active low |

## Verification
Two events can coincide in the ending T2 of a word access: ready arrives and the 8-bit width input is active. The sequencer must then start a fresh T1 instead of finishing, so the bench drives both in the same clock. It checks that no `done` appears, that the strobe returns with address bit 0 set, and that the merged word appears only after the second half. A second collision is the `done` clock of one request with the acceptance of the next. The bench presents a new request exactly on the `done` clock and expects its strobe in the following clock.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic          req_dc,
  input  logic          req_word,
  input  logic          req_refresh,
  input  logic          req_local,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          bus_ads_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_bhe_n,
  output logic          bus_ble_n,
  output logic          bus_wr,
  output logic          bus_mem,
  output logic          bus_dc,
  output logic          bus_refresh,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_ready_n,
  input  logic          bus_size8_n,
  output logic          bus_local_n
);
  localparam int BW = DW / 2;
  localparam logic [1:0] S_IDLE = 2'd0, S_T1 = 2'd1, S_T2 = 2'd2;

  logic [1:0]    st;
  logic          q_word, q_local, split2;
  logic [BW-1:0] hi_wbyte, lo_rbyte;
  logic          accept, t2_end, go_split;

  assign req_ready = (st == S_IDLE);
  assign bus_ads_n = (st != S_T1);
  assign accept    = req_valid && req_ready;
  assign t2_end    = (st == S_T2) && (q_local || !bus_ready_n);
  assign go_split  = t2_end && q_word && !bus_refresh && !split2 && !bus_size8_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      q_word      <= 1'b0;
      q_local     <= 1'b0;
      split2      <= 1'b0;
      hi_wbyte    <= '0;
      lo_rbyte    <= '0;
      bus_addr    <= '0;
      bus_bhe_n   <= 1'b1;
      bus_ble_n   <= 1'b1;
      bus_wr      <= 1'b0;
      bus_mem     <= 1'b0;
      bus_dc      <= 1'b0;
      bus_refresh <= 1'b0;
      bus_dout    <= '0;
      bus_doe     <= 1'b0;
      bus_local_n <= 1'b1;
      done        <= 1'b0;
      rd_data     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st          <= S_T1;
          q_word      <= req_word && !req_refresh;
          q_local     <= req_local;
          split2      <= 1'b0;
          hi_wbyte    <= req_wdata[DW-1:BW];
          bus_addr    <= (req_word && !req_refresh) ? {req_addr[AW-1:1], 1'b0} : req_addr;
          bus_wr      <= req_write && !req_refresh;
          bus_mem     <= req_mem;
          bus_dc      <= req_dc;
          bus_refresh <= req_refresh;
          bus_dout    <= req_wdata;
          bus_doe     <= req_write && !req_refresh;
          if (req_refresh) begin
            bus_bhe_n <= 1'b1;
            bus_ble_n <= 1'b1;
          end else if (req_word) begin
            bus_bhe_n <= 1'b0;
            bus_ble_n <= 1'b0;
          end else begin
            bus_bhe_n <= !req_addr[0];
            bus_ble_n <= req_addr[0];
          end
        end
        S_T1: begin
          st          <= S_T2;
          bus_local_n <= !q_local;
        end
        S_T2: if (t2_end) begin
          if (go_split) begin
            st          <= S_T1;
            split2      <= 1'b1;
            lo_rbyte    <= bus_din[BW-1:0];
            bus_addr[0] <= 1'b1;
            bus_bhe_n   <= 1'b1;
            bus_ble_n   <= 1'b0;
            bus_dout    <= {hi_wbyte, hi_wbyte};
          end else begin
            st      <= S_IDLE;
            done    <= 1'b1;
            bus_doe <= 1'b0;
            rd_data <= split2 ? {bus_din[BW-1:0], lo_rbyte} : bus_din;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    st,
  input logic          q_local,
  input logic          split2,
  input logic          req_ready,
  input logic          done,
  input logic          bus_ads_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_bhe_n,
  input logic          bus_ble_n,
  input logic          bus_refresh,
  input logic          bus_doe,
  input logic          bus_ready_n
);
  localparam logic [1:0] C_T2 = 2'd2;

  p_strobe_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |=> bus_ads_n);

  p_refresh_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_refresh |-> (bus_bhe_n && bus_ble_n));

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_T2 && bus_ready_n && !q_local) |=>
      (st == C_T2 && $stable(bus_addr) && $stable(bus_bhe_n) && $stable(bus_ble_n) && !done));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_internal_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_T2 && q_local) |=> (st != C_T2));

  p_split_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (split2 && !bus_ads_n) |-> (bus_addr[0] && bus_bhe_n && !bus_ble_n));

  p_refresh_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_refresh |-> !bus_doe);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_ads_n && !bus_doe));
endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .q_local(q_local), .split2(split2),
  .req_ready(req_ready), .done(done), .bus_ads_n(bus_ads_n), .bus_addr(bus_addr),
  .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n), .bus_refresh(bus_refresh),
  .bus_doe(bus_doe), .bus_ready_n(bus_ready_n)
);

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
  localparam int AW = 24;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b1, req_dc = 1'b1;
  logic req_word = 1'b0, req_refresh = 1'b0, req_local = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic bus_ready_n = 1'b1, bus_size8_n = 1'b1;
  logic req_ready, done, bus_ads_n, bus_bhe_n, bus_ble_n, bus_wr, bus_mem, bus_dc;
  logic bus_refresh, bus_doe, bus_local_n;
  logic [DW-1:0] rd_data, bus_dout;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) i_bus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem), .req_dc(req_dc),
    .req_word(req_word), .req_refresh(req_refresh), .req_local(req_local),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .bus_ads_n(bus_ads_n),
    .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n), .bus_wr(bus_wr),
    .bus_mem(bus_mem), .bus_dc(bus_dc), .bus_refresh(bus_refresh), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_ready_n(bus_ready_n),
    .bus_size8_n(bus_size8_n), .bus_local_n(bus_local_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic w, input logic wd,
                       input logic rf, input logic loc, input logic [DW-1:0] wdat);
    req_valid = 1'b1; req_addr = a; req_write = w; req_word = wd;
    req_refresh = rf; req_local = loc; req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic end_t2(input logic [DW-1:0] d, input logic s8n);
    bus_ready_n = 1'b0; bus_din = d; bus_size8_n = s8n;
    @(negedge clk);
    bus_ready_n = 1'b1; bus_size8_n = 1'b1;
  endtask

  task automatic t_reset;
    chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
    chk(bus_ads_n === 1'b1, "R1 ads_n", 32'(bus_ads_n), 1);
    chk({bus_bhe_n, bus_ble_n} === 2'b11, "R1 enables", 32'({bus_bhe_n, bus_ble_n}), 3);
    chk({bus_refresh, bus_doe, done} === 3'b000, "R1 refresh/doe/done",
        32'({bus_refresh, bus_doe, done}), 0);
    chk(bus_local_n === 1'b1, "R1 local_n", 32'(bus_local_n), 1);
  endtask

  task automatic t_word_read_waits;
    issue(24'h001235, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    chk(bus_ads_n === 1'b0, "R2 strobe in T1", 32'(bus_ads_n), 0);
    chk(req_ready === 1'b0, "R12 busy in T1", 32'(req_ready), 0);
    chk({bus_bhe_n, bus_ble_n} === 2'b00, "R3 word enables", 32'({bus_bhe_n, bus_ble_n}), 0);
    chk(bus_addr === 24'h001234, "R3 word addr bit0 clear", 32'(bus_addr), 32'h1234);
    @(negedge clk);
    chk(bus_ads_n === 1'b1, "R2 strobe off in T2", 32'(bus_ads_n), 1);
    bus_size8_n = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(done === 1'b0 && bus_addr === 24'h001234 && bus_ads_n === 1'b1,
          "R4 wait state holds", 32'({done, bus_ads_n}), 1);
    end
    end_t2(16'hA5C3, 1'b1);
    chk(done === 1'b1, "R5 done after ready", 32'(done), 1);
    chk(rd_data === 16'hA5C3, "R5 read data", 32'(rd_data), 32'hA5C3);
    chk(bus_ads_n === 1'b1, "R10 size8 during wait ignored", 32'(bus_ads_n), 1);
    @(negedge clk);
    chk(done === 1'b0, "R5 done one clock", 32'(done), 0);
  endtask

  task automatic t_byte_write_odd;
    issue(24'h000101, 1'b1, 1'b0, 1'b0, 1'b0, 16'h7700);
    chk({bus_bhe_n, bus_ble_n} === 2'b01, "R3 odd byte enables", 32'({bus_bhe_n, bus_ble_n}), 1);
    chk(bus_doe === 1'b1 && bus_dout === 16'h7700 && bus_wr === 1'b1, "R6 write data in T1",
        32'(bus_dout), 32'h7700);
    @(negedge clk);
    chk(bus_doe === 1'b1, "R6 write data in T2", 32'(bus_doe), 1);
    end_t2(16'h0000, 1'b1);
    chk(done === 1'b1 && bus_doe === 1'b0, "R6 doe off in idle", 32'({done, bus_doe}), 2);
  endtask

  task automatic t_byte_even_size8;
    issue(24'h000200, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk({bus_bhe_n, bus_ble_n} === 2'b10, "R3 even byte enables", 32'({bus_bhe_n, bus_ble_n}), 2);
    @(negedge clk);
    end_t2(16'h3C5A, 1'b0);
    chk(done === 1'b1 && rd_data === 16'h3C5A, "R10 size8 ignored on byte", 32'(rd_data), 32'h3C5A);
  endtask

  task automatic t_local;
    issue(24'h000400, 1'b0, 1'b0, 1'b0, 1'b1, '0);
    @(negedge clk);
    chk(bus_local_n === 1'b0, "R8 local low in first T2", 32'(bus_local_n), 0);
    bus_din = 16'h0042;
    @(negedge clk);
    chk(done === 1'b1, "R7 internal ready ends T2", 32'(done), 1);
    chk(bus_local_n === 1'b0, "R8 local held in idle", 32'(bus_local_n), 0);
    @(negedge clk);
    issue(24'h000402, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk(bus_local_n === 1'b0, "R8 local held in next T1", 32'(bus_local_n), 0);
    @(negedge clk);
    chk(bus_local_n === 1'b1, "R8 local released in T2", 32'(bus_local_n), 1);
    end_t2(16'h0001, 1'b1);
  endtask

  task automatic t_split_read;
    issue(24'h000800, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);
    end_t2(16'hFF11, 1'b0);
    chk(done === 1'b0 && bus_ads_n === 1'b0, "R9 second T1 no done", 32'({done, bus_ads_n}), 0);
    chk(bus_addr === 24'h000801, "R9 second addr bit0", 32'(bus_addr), 32'h801);
    chk({bus_bhe_n, bus_ble_n} === 2'b10, "R9 second enables", 32'({bus_bhe_n, bus_ble_n}), 2);
    @(negedge clk);
    end_t2(16'hEE22, 1'b0);
    chk(done === 1'b1, "R9 single done", 32'(done), 1);
    chk(rd_data === 16'h2211, "R9 merged word", 32'(rd_data), 32'h2211);
  endtask

  task automatic t_split_write;
    issue(24'h000A00, 1'b1, 1'b1, 1'b0, 1'b0, 16'hBEEF);
    @(negedge clk);
    end_t2(16'h0000, 1'b0);
    chk(bus_dout[7:0] === 8'hBE && bus_doe === 1'b1, "R9 upper byte on low lane",
        32'(bus_dout), 32'hBEBE);
    @(negedge clk);
    end_t2(16'h0000, 1'b1);
    chk(done === 1'b1, "R9 split write done", 32'(done), 1);
  endtask

  task automatic t_refresh_back_to_back;
    issue(24'h000010, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1111);
    chk({bus_bhe_n, bus_ble_n, bus_refresh} === 3'b111, "R3 refresh encoding",
        32'({bus_bhe_n, bus_ble_n, bus_refresh}), 7);
    chk(bus_doe === 1'b0, "R11 refresh no data", 32'(bus_doe), 0);
    @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R11 refresh waits for ready", 32'(done), 0);
    end_t2(16'h0000, 1'b0);
    chk(done === 1'b1 && req_ready === 1'b1, "R11 refresh ends on ready", 32'({done, req_ready}), 3);
    issue(24'h000020, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk(bus_ads_n === 1'b0 && bus_refresh === 1'b0, "R12 back-to-back T1",
        32'({bus_ads_n, bus_refresh}), 0);
    @(negedge clk);
    end_t2(16'h0055, 1'b1);
    chk(done === 1'b1 && rd_data === 16'h0055, "R12 second request done", 32'(rd_data), 32'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_read_waits();
    t_byte_write_odd();
    t_byte_even_size8();
    t_local();
    t_split_read();
    t_split_write();
    t_refresh_back_to_back();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule